// File: doc/BRIEF.md
# Serial Shift/Capture/Update Register Port

This block is a serial access port that sits in front of the image-upgrade control logic. It holds a 41-bit shift chain and a 39-bit input register. Both are clocked on the rising edge of a dedicated port clock. Two mode pins choose between three operations:

- **Shift** moves the chain by one position.
- **Capture** loads a status word into the low 39 chain bits.
- **Update** commits the low 39 chain bits to the input register.

The two most significant chain bits form an in-band address. Their value chooses which word a capture loads:

- the current-state word,
- either of two previous-state records,
- or the input register itself.

The surrounding logic reaches several status words through a single serial chain, much like a JTAG data register. The input register drives the image-select and select-override outputs.

Software-side logic sets a word up as follows. It shifts in 39 bits, least significant bit first, so that the last two bits also land in the address field. It then issues capture or update, and reads results back through the serial output.

Top module: `sreg_port`

## Requirements
- R1: While `shiftEn` is 1, `captureSel` is ignored and every rising edge shifts the chain. The low 39 bits become `{serIn, chain[38:1]}` and the address bits `chain[40:39]` become `{serIn, chain[40]}`. A word shifted in LSB first therefore ends with its bits 38 and 37 in `chain[40]` and `chain[39]`.
- R2: `serOut` always presents `chain[0]`, so chain contents leave least significant bit first.
- R3: With `shiftEn`=0 and `captureSel`=0, the input register takes `chain[38:0]`, with every bit other than 13 and 12 forced to 0. `imageSel` shows input-register bit 13 and `selOverride` shows bit 12.
- R4: With `shiftEn`=0 and `captureSel`=1, `chain[38:0]` is loaded according to `chain[40:39]`:
  - 00 selects the 34-bit current-state word (state code 33:30, watchdog enable 29, time-out 28:0);
  - 01 selects previous-state record 1;
  - 10 selects previous-state record 2;
  - 11 selects the input register.
- R5: Captured sources narrower than 39 bits (the 34-bit current-state word and the 32-bit records) are zero-extended.
- R6: The input register, and with it `imageSel` and `selOverride`, changes only on an update.
- R7: `chain[40:39]` keeps its value through capture and update, so one address serves repeated operations.
- R8: While `rstN` is low, the chain and the input register are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| shiftEn | input | 1 | 1 = shift; 0 = capture or update |
| captureSel | input | 1 | With shiftEn=0: 1 = capture, 0 = update |
| serIn | input | 1 | Serial data into the chain |
| serOut | output | 1 | Serial data out, chain bit 0 |
| curState | input | 34 | Current-state word |
| prevRec1 | input | 32 | Previous-state record 1 |
| prevRec2 | input | 32 | Previous-state record 2 |
| imageSel | output | 1 | Input-register image select (bit 13) |
| selOverride | output | 1 | Input-register select-override enable (bit 12) |

## Verification
A wrong address decode or a missing zero-extension shows up on `serOut` within the 39 shifts that follow a capture. Because each source carries a distinct pattern, the wrong source or a stray high bit is recognisable.

An address field that drifts during capture or update is exposed when two captures in a row, with no shift between them, return different sources.

A leak of reserved bits, or a write to the input register outside update, appears directly on `imageSel` and `selOverride` one edge later. It also appears in the word read back through capture code 11.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;

  typedef struct packed {
    logic doShift;
    logic doCapture;
    logic doUpdate;
  } strobe_t;

  typedef enum logic [1:0] {
    SRC_CUR   = 2'b00,
    SRC_PREV1 = 2'b01,
    SRC_PREV2 = 2'b10,
    SRC_INREG = 2'b11
  } capSrc_e;

endpackage

// File: rtl/sreg_port_ctrl.sv
module sreg_port_ctrl
  import sreg_port_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shiftEn,
  input  logic    captureSel,
  output strobe_t strobes
);

  always_comb begin
    strobes.doShift   = shiftEn;
    strobes.doCapture = !shiftEn && captureSel;
    strobes.doUpdate  = !shiftEn && !captureSel;
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doShift, strobes.doCapture, strobes.doUpdate}));

  // R1
  shift_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> !strobes.doCapture && !strobes.doUpdate);

endmodule

// File: rtl/sreg_port_dp.sv
module sreg_port_dp
  import sreg_port_pkg::*;
#(
  parameter int SR_W    = 41,
  parameter int IN_W    = 39,
  parameter int CUR_W   = 34,
  parameter int PREV_W  = 32,
  parameter int SEL_BIT = 13,
  parameter int OVR_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              serIn,
  input  logic [CUR_W-1:0]  curState,
  input  logic [PREV_W-1:0] prevRec1,
  input  logic [PREV_W-1:0] prevRec2,
  output logic              serOut,
  output logic              imageSel,
  output logic              selOverride
);

  localparam int ADDR_W = SR_W - IN_W;
  localparam logic [IN_W-1:0] KEEP_MASK = (IN_W'(1) << SEL_BIT) | (IN_W'(1) << OVR_BIT);

  logic [SR_W-1:0]  chain;
  logic [IN_W-1:0]  inReg;
  logic [IN_W-1:0]  capWord;
  logic [ADDR_W-1:0] addrNext;
  capSrc_e          capSrc;

  assign capSrc = capSrc_e'(chain[SR_W-1 -: ADDR_W]);

  always_comb begin
    unique case (capSrc)
      SRC_CUR:   capWord = {{(IN_W-CUR_W){1'b0}}, curState};
      SRC_PREV1: capWord = {{(IN_W-PREV_W){1'b0}}, prevRec1};
      SRC_PREV2: capWord = {{(IN_W-PREV_W){1'b0}}, prevRec2};
      default:   capWord = inReg;
    endcase
  end

  assign addrNext = {serIn, chain[SR_W-1:IN_W+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else if (strobes.doShift) begin
      chain <= {addrNext, serIn, chain[IN_W-1:1]};
    end else if (strobes.doCapture) begin
      chain[IN_W-1:0] <= capWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      inReg <= '0;
    else if (strobes.doUpdate)
      inReg <= chain[IN_W-1:0] & KEEP_MASK;
  end

  assign serOut      = chain[0];
  assign imageSel    = inReg[SEL_BIT];
  assign selOverride = inReg[OVR_BIT];

  // R2
  shift_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doShift |=> serOut == $past(chain[1]));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCapture || strobes.doUpdate) |=> $stable(chain[SR_W-1:IN_W]));

  // R3
  update_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doUpdate |=> imageSel == $past(chain[SEL_BIT]) &&
                         selOverride == $past(chain[OVR_BIT]));

  // R6
  inreg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doUpdate |=> $stable(imageSel) && $stable(selOverride));

  // R4 R5
  cap_cur_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doCapture && capSrc == SRC_CUR) |=>
      chain[IN_W-1:0] == {{(IN_W-CUR_W){1'b0}}, $past(curState)});

endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftEn,
  input  logic        captureSel,
  input  logic        serIn,
  output logic        serOut,
  input  logic [33:0] curState,
  input  logic [31:0] prevRec1,
  input  logic [31:0] prevRec2,
  output logic        imageSel,
  output logic        selOverride
);

  strobe_t strobes;

  sreg_port_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .shiftEn    (shiftEn),
    .captureSel (captureSel),
    .strobes    (strobes)
  );

  sreg_port_dp #(
    .SR_W    (41),
    .IN_W    (39),
    .CUR_W   (34),
    .PREV_W  (32),
    .SEL_BIT (13),
    .OVR_BIT (12)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .serIn       (serIn),
    .curState    (curState),
    .prevRec1    (prevRec1),
    .prevRec2    (prevRec2),
    .serOut      (serOut),
    .imageSel    (imageSel),
    .selOverride (selOverride)
  );

endmodule

// File: tb/sreg_port_tb.sv
module sreg_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        shiftEn = 1'b0;
  logic        captureSel = 1'b0;
  logic        serIn = 1'b0;
  logic        serOut;
  logic [33:0] curState = '0;
  logic [31:0] prevRec1 = '0;
  logic [31:0] prevRec2 = '0;
  logic        imageSel;
  logic        selOverride;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sreg_port u_dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .captureSel(captureSel),
    .serIn(serIn), .serOut(serOut), .curState(curState),
    .prevRec1(prevRec1), .prevRec2(prevRec2),
    .imageSel(imageSel), .selOverride(selOverride)
  );

  task automatic chk(input string req, input logic [38:0] got, input logic [38:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one rising edge with the given controls, then settle 1 ns past it
  task automatic cycle(input logic sh, input logic cu, input logic d);
    shiftEn = sh; captureSel = cu; serIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic shiftWord(input logic [38:0] w, input logic cu);
    for (int i = 0; i < 39; i++) cycle(1'b1, cu, w[i]);
  endtask

  task automatic readWord(output logic [38:0] got);
    for (int i = 0; i < 39; i++) begin
      got[i] = serOut;
      cycle(1'b1, 1'b0, 1'b0);
    end
  endtask

  task automatic testReset();
    chk("R8 serOut after reset", {38'b0, serOut}, 39'b0);
    chk("R8 input fields after reset", {37'b0, imageSel, selOverride}, 39'b0);
  endtask

  task automatic testShift();
    logic [38:0] got;
    logic [38:0] w = 39'h5A_C3F0_1E69;
    shiftWord(w, 1'b1);           // captureSel high must be ignored (R1)
    chk("R2 serOut shows bit0", {38'b0, serOut}, {38'b0, w[0]});
    readWord(got);
    chk("R1 shift ignores captureSel", got, w);
  endtask

  task automatic testUpdateAndInReg();
    logic [38:0] got;
    // bits 38:37 = 11 -> address code 11; bits 13,12 set; reserved garbage too
    logic [38:0] w = 39'h7F_FFFF_F0F3 | (39'b1 << 13) | (39'b1 << 12);
    shiftWord(w, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);      // update
    chk("R3 imageSel/selOverride after update", {37'b0, imageSel, selOverride}, 39'b11);
    cycle(1'b0, 1'b1, 1'b0);      // capture code 11, address kept through update (R7)
    readWord(got);
    chk("R3 R4 R7 input register reads back masked", got, (39'b1 << 13) | (39'b1 << 12));
  endtask

  task automatic testCaptureCur();
    logic [38:0] got;
    curState = 34'h3_9ABC_DEF1;
    shiftWord(39'h1F_FFFF_FFFF, 1'b0);   // bits 38:37 = 00
    cycle(1'b0, 1'b1, 1'b0);
    chk("R6 inputs hold across capture", {37'b0, imageSel, selOverride}, 39'b11);
    readWord(got);
    chk("R4 R5 capture code 00 current state", got, {5'b0, curState});
  endtask

  task automatic testCapturePrev1();
    logic [38:0] got;
    prevRec1 = 32'hDEAD_BEEF;
    shiftWord(39'h20_0000_0000, 1'b0);   // bit38=0 bit37=1 -> code 01
    cycle(1'b0, 1'b1, 1'b0);
    prevRec1 = 32'h8421_7BDE;
    cycle(1'b0, 1'b1, 1'b0);             // second capture, same address (R7)
    readWord(got);
    chk("R4 R5 R7 capture code 01 record 1", got, {7'b0, 32'h8421_7BDE});
  endtask

  task automatic testCapturePrev2();
    logic [38:0] got;
    prevRec2 = 32'hFFFF_FFFF;
    shiftWord(39'h40_0000_0000, 1'b0);   // bit38=1 bit37=0 -> code 10
    cycle(1'b0, 1'b1, 1'b0);
    readWord(got);
    chk("R4 R5 capture code 10 record 2", got, {7'b0, 32'hFFFF_FFFF});
  endtask

  task automatic testUpdateClears();
    shiftWord(39'h0, 1'b0);
    chk("R6 shift leaves input fields", {37'b0, imageSel, selOverride}, 39'b11);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R3 update with zero bits clears fields", {37'b0, imageSel, selOverride}, 39'b0);
    shiftWord(39'b1 << 13, 1'b0);
    cycle(1'b0, 1'b0, 1'b0);
    chk("R3 image select alone", {37'b0, imageSel, selOverride}, 39'b10);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    cycle(1'b0, 1'b1, 1'b0);
    testShift();
    testUpdateAndInReg();
    testCaptureCur();
    testCapturePrev1();
    testCapturePrev2();
    testUpdateClears();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule